// File: doc/BRIEF.md
# Cached-Payload Transmit Engine

This block is the transmit side of a network adapter that keeps received and previously sent payloads in on-card staging memory. The host posts transmit descriptors; each one names a staging entry, a host address, a payload length, a header length, and a flag telling whether that entry already holds the payload. On a hit the engine streams the payload directly out of the named entry. On a miss it first reads the payload from host memory over a simple fetch port into that entry, and only then streams it.

Header words travel on their own input stream and are placed in front of the payload on the output stream. Because headers never pass through staging memory, a forwarder can rewrite them freely while reusing a retained payload. A direct-forwarding mode input turns a miss into a drop: nothing is fetched or sent, the header words for that packet are consumed and discarded, and the completion event reports the drop.

Every descriptor ends in exactly one completion pulse that returns its entry number. Descriptors are queued and serviced one at a time in arrival order.

Top module: `pc_tx_engine`

## Requirements
- R1: Descriptors are serviced strictly in the order they were accepted. Up to FIFO_DEPTH descriptors wait while one is in service, and `desc_ready` is low while that queue is full.
- R2: A descriptor with `desc_hit`=1 sends `desc_len` payload words read from staging entry `desc_entry`, and raises no `fetch_req` while it is in service.
- R3: A descriptor with `desc_hit`=0 outside direct mode raises `fetch_req` with `fetch_addr`=`desc_addr` and `fetch_len`=`desc_len`. These are held until `fetch_ack`. The next `desc_len` cycles with `fetch_dvalid`=1 are written to word 0 upward of the named entry, and those words are then sent.
- R4: A staging entry keeps its payload until a later fetch writes the same entry. Descriptors for other entries, hits on it, and different header words do not change what a hit on that entry sends.
- R5: `desc_hdr_len` words taken from the header stream go out before the payload, with `tx_last`=0. `tx_last`=1 marks only the final payload word, and a header length of 0 sends the payload alone.
- R6: With `direct_mode`=1 when a miss descriptor starts, no fetch is issued and no output word is sent. Its `desc_hdr_len` header words are consumed with `hdr_ready`=1, and completion reports `cmp_dropped`=1. Hit descriptors in direct mode are sent normally.
- R7: Each descriptor produces exactly one single-cycle `cmp_valid` pulse, in descriptor order, with `cmp_entry` equal to its entry. For a sent packet the pulse comes in the cycle right after the handshake of the word with `tx_last`=1, with `cmp_dropped`=0.
- R8: While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R9: While reset is asserted and right after it, `tx_valid`, `fetch_req`, `hdr_ready` and `cmp_valid` are 0 and `desc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_mode | input | 1 | Drop misses instead of fetching them |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor queue has room |
| desc_entry | input | ENT_W | Staging entry number |
| desc_hit | input | 1 | Entry already holds the payload |
| desc_addr | input | ADDR_W | Host address of the payload |
| desc_len | input | IDX_W+1 | Payload words, 1 to 2**IDX_W |
| desc_hdr_len | input | HL_W | Header words to prepend |
| hdr_valid | input | 1 | Header word offered |
| hdr_ready | output | 1 | Header word taken |
| hdr_data | input | DATA_W | Header word |
| fetch_req | output | 1 | Host read request |
| fetch_ack | input | 1 | Host read request accepted |
| fetch_addr | output | ADDR_W | Host read address |
| fetch_len | output | IDX_W+1 | Host read length in words |
| fetch_dvalid | input | 1 | Host read data word present |
| fetch_data | input | DATA_W | Host read data word |
| tx_valid | output | 1 | Output word present |
| tx_ready | input | 1 | Output word taken |
| tx_data | output | DATA_W | Output word |
| tx_last | output | 1 | Final word of the frame |
| cmp_valid | output | 1 | Completion pulse |
| cmp_entry | output | ENT_W | Entry of the finished descriptor |
| cmp_dropped | output | 1 | Descriptor was dropped in direct mode |

## Verification
On every cycle, the assertions check that no fetch appears while a hit is in service or during a drop, that the fetch request stays stable until it is accepted, that the output word holds under backpressure, and that a send completion follows its final-word handshake. The rest needs the bench's scenarios: that the right bytes come out at all, that a payload survives traffic to other entries and is replaced only by a later fetch into the same entry, that descriptors keep their order through a full queue, and that a drop swallows exactly its own header words without shifting the headers of the next packet.

// File: rtl/pc_tx_pkg.sv
package pc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_FILL,
      ST_HDR,
      ST_PAY,
      ST_DROP
   } tx_state_e;

endpackage

// File: rtl/pc_desc_fifo.sv
module pc_desc_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_pop,
   output logic [WIDTH-1:0] out_data
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pc_desc_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic             full_q;
      logic [WIDTH-1:0] slot_q;

      assign in_ready  = !full_q;
      assign out_valid = full_q;
      assign out_data  = slot_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            slot_q <= '0;
         end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            slot_q <= in_data;
         end else if (out_pop) begin
            full_q <= 1'b0;
         end
      end
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(DEPTH + 1);
      localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
      localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
      localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
      localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

      logic [WIDTH-1:0] slots_q [DEPTH];
      logic [PTR_W-1:0] wp_q, rp_q;
      logic [CNT_W-1:0] cnt_q;
      logic             push;

      assign in_ready  = (cnt_q != CNT_FULL);
      assign out_valid = (cnt_q != '0);
      assign out_data  = slots_q[rp_q];
      assign push      = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + PTR_ONE;
            if (out_pop) rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + PTR_ONE;
            if (push && !out_pop) cnt_q <= cnt_q + CNT_ONE;
            else if (!push && out_pop) cnt_q <= cnt_q - CNT_ONE;
         end
      end

      always_ff @(posedge clk) begin
         if (push) slots_q[wp_q] <= in_data;
      end

      // R1
      fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CNT_FULL);
   end

   // R1
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_pop |-> out_valid);

endmodule

// File: rtl/pc_entry_store.sv
module pc_entry_store #(
   parameter int DATA_W = 8,
   parameter int ENT_W  = 3,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ENT_W-1:0]  wr_entry,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ENT_W-1:0]  rd_entry,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam int WORDS = 2 ** (ENT_W + IDX_W);

   if (WORDS > 4096) begin : g_too_big
      $error("pc_entry_store: staging memory exceeds 4096 words");
   end

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{wr_entry, wr_idx}] <= wr_data;
   end

   assign rd_data = mem_q[{rd_entry, rd_idx}];

endmodule

// File: rtl/pc_tx_engine.sv
module pc_tx_engine #(
   parameter int DATA_W     = 8,
   parameter int ENT_W      = 3,
   parameter int IDX_W      = 4,
   parameter int ADDR_W     = 16,
   parameter int HL_W       = 3,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              direct_mode,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [ENT_W-1:0]  desc_entry,
   input  logic              desc_hit,
   input  logic [ADDR_W-1:0] desc_addr,
   input  logic [IDX_W:0]    desc_len,
   input  logic [HL_W-1:0]   desc_hdr_len,
   input  logic              hdr_valid,
   output logic              hdr_ready,
   input  logic [DATA_W-1:0] hdr_data,
   output logic              fetch_req,
   input  logic              fetch_ack,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [IDX_W:0]    fetch_len,
   input  logic              fetch_dvalid,
   input  logic [DATA_W-1:0] fetch_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   output logic              cmp_valid,
   output logic [ENT_W-1:0]  cmp_entry,
   output logic              cmp_dropped
);
   import pc_tx_pkg::*;

   localparam int DESC_W = ENT_W + 1 + ADDR_W + (IDX_W + 1) + HL_W;
   localparam logic [IDX_W:0]  LEN_ONE = (IDX_W + 1)'(1);
   localparam logic [HL_W-1:0] HL_ONE  = HL_W'(1);

   if (IDX_W < 1 || ENT_W < 1 || HL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pc_tx_engine: widths must be at least 1");
   end

   // descriptor queue
   logic [DESC_W-1:0] push_word, head_word;
   logic              head_valid, head_pop;
   logic [ENT_W-1:0]  h_entry;
   logic              h_hit;
   logic [ADDR_W-1:0] h_addr;
   logic [IDX_W:0]    h_len;
   logic [HL_W-1:0]   h_hlen;

   assign push_word = {desc_entry, desc_hit, desc_addr, desc_len, desc_hdr_len};
   assign {h_entry, h_hit, h_addr, h_len, h_hlen} = head_word;

   pc_desc_fifo #(.WIDTH(DESC_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (desc_valid),
      .in_ready (desc_ready),
      .in_data  (push_word),
      .out_valid(head_valid),
      .out_pop  (head_pop),
      .out_data (head_word)
   );

   // current descriptor
   tx_state_e         state;
   logic [ENT_W-1:0]  cur_entry;
   logic              cur_hit;
   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W:0]    cur_len;
   logic [HL_W-1:0]   cur_hlen;
   logic [IDX_W:0]    idx;
   logic [HL_W-1:0]   hcnt;
   logic              word_last, hdr_last;
   logic [DATA_W-1:0] rd_data;

   assign head_pop   = (state == ST_IDLE) && head_valid;
   assign word_last  = (idx == cur_len - LEN_ONE);
   assign hdr_last   = (hcnt == cur_hlen - HL_ONE);
   assign fetch_addr = cur_addr;
   assign fetch_len  = cur_len;

   pc_entry_store #(.DATA_W(DATA_W), .ENT_W(ENT_W), .IDX_W(IDX_W)) i_store (
      .clk     (clk),
      .wr_en   ((state == ST_FILL) && fetch_dvalid),
      .wr_entry(cur_entry),
      .wr_idx  (idx[IDX_W-1:0]),
      .wr_data (fetch_data),
      .rd_entry(cur_entry),
      .rd_idx  (idx[IDX_W-1:0]),
      .rd_data (rd_data)
   );

   always_comb begin
      fetch_req = (state == ST_REQ);
      hdr_ready = 1'b0;
      tx_valid  = 1'b0;
      tx_data   = '0;
      tx_last   = 1'b0;
      case (state)
         ST_HDR: begin
            tx_valid  = hdr_valid;
            tx_data   = hdr_data;
            hdr_ready = tx_ready;
         end
         ST_PAY: begin
            tx_valid = 1'b1;
            tx_data  = rd_data;
            tx_last  = word_last;
         end
         ST_DROP: hdr_ready = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur_entry   <= '0;
         cur_hit     <= 1'b0;
         cur_addr    <= '0;
         cur_len     <= '0;
         cur_hlen    <= '0;
         idx         <= '0;
         hcnt        <= '0;
         cmp_valid   <= 1'b0;
         cmp_entry   <= '0;
         cmp_dropped <= 1'b0;
      end else begin
         cmp_valid <= 1'b0;
         case (state)
            ST_IDLE: if (head_valid) begin
               cur_entry <= h_entry;
               cur_hit   <= h_hit;
               cur_addr  <= h_addr;
               cur_len   <= h_len;
               cur_hlen  <= h_hlen;
               idx       <= '0;
               hcnt      <= '0;
               if (h_hit) begin
                  state <= (h_hlen != '0) ? ST_HDR : ST_PAY;
               end else if (direct_mode) begin
                  if (h_hlen != '0) begin
                     state <= ST_DROP;
                  end else begin
                     cmp_valid   <= 1'b1;
                     cmp_entry   <= h_entry;
                     cmp_dropped <= 1'b1;
                  end
               end else begin
                  state <= ST_REQ;
               end
            end
            ST_REQ: if (fetch_ack) state <= ST_FILL;
            ST_FILL: if (fetch_dvalid) begin
               if (word_last) begin
                  idx   <= '0;
                  state <= (cur_hlen != '0) ? ST_HDR : ST_PAY;
               end else begin
                  idx <= idx + LEN_ONE;
               end
            end
            ST_HDR: if (hdr_valid && tx_ready) begin
               if (hdr_last) begin
                  hcnt  <= '0;
                  state <= ST_PAY;
               end else begin
                  hcnt <= hcnt + HL_ONE;
               end
            end
            ST_PAY: if (tx_ready) begin
               if (word_last) begin
                  idx         <= '0;
                  state       <= ST_IDLE;
                  cmp_valid   <= 1'b1;
                  cmp_entry   <= cur_entry;
                  cmp_dropped <= 1'b0;
               end else begin
                  idx <= idx + LEN_ONE;
               end
            end
            ST_DROP: if (hdr_valid) begin
               if (hdr_last) begin
                  hcnt        <= '0;
                  state       <= ST_IDLE;
                  cmp_valid   <= 1'b1;
                  cmp_entry   <= cur_entry;
                  cmp_dropped <= 1'b1;
               end else begin
                  hcnt <= hcnt + HL_ONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && cur_hit) |-> !fetch_req);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr) && $stable(fetch_len)));

   // R6
   drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DROP) |-> (!fetch_req && !tx_valid));

   // R7
   cmp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !cmp_dropped) |-> $past(tx_valid && tx_ready && tx_last));

   // R8
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

endmodule

// File: tb/test_pc_tx_engine.sv
module test_pc_tx_engine;

   localparam int DATA_W = 8;
   localparam int ENT_W  = 3;
   localparam int IDX_W  = 4;
   localparam int ADDR_W = 16;
   localparam int HL_W   = 3;
   localparam int NENT   = 2 ** ENT_W;
   localparam int MAXW   = 2 ** IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              direct_mode = 1'b0;
   logic              desc_valid = 1'b0;
   logic              desc_ready;
   logic [ENT_W-1:0]  desc_entry = '0;
   logic              desc_hit = 1'b0;
   logic [ADDR_W-1:0] desc_addr = '0;
   logic [IDX_W:0]    desc_len = '0;
   logic [HL_W-1:0]   desc_hdr_len = '0;
   logic              hdr_valid = 1'b0;
   logic              hdr_ready;
   logic [DATA_W-1:0] hdr_data = '0;
   logic              fetch_req;
   logic              fetch_ack = 1'b0;
   logic [ADDR_W-1:0] fetch_addr;
   logic [IDX_W:0]    fetch_len;
   logic              fetch_dvalid = 1'b0;
   logic [DATA_W-1:0] fetch_data = '0;
   logic              tx_valid;
   logic              tx_ready = 1'b1;
   logic [DATA_W-1:0] tx_data;
   logic              tx_last;
   logic              cmp_valid;
   logic [ENT_W-1:0]  cmp_entry;
   logic              cmp_dropped;

   always #2.5 clk = ~clk;

   pc_tx_engine #(
      .DATA_W(DATA_W), .ENT_W(ENT_W), .IDX_W(IDX_W),
      .ADDR_W(ADDR_W), .HL_W(HL_W), .FIFO_DEPTH(4)
   ) i_pc_tx_engine (
      .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_entry(desc_entry),
      .desc_hit(desc_hit), .desc_addr(desc_addr), .desc_len(desc_len),
      .desc_hdr_len(desc_hdr_len), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_data(hdr_data), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
      .fetch_addr(fetch_addr), .fetch_len(fetch_len), .fetch_dvalid(fetch_dvalid),
      .fetch_data(fetch_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_last(tx_last), .cmp_valid(cmp_valid),
      .cmp_entry(cmp_entry), .cmp_dropped(cmp_dropped)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int rdy_mode = 0;
   int hdr_seed = 8'h40;
   int beats_seen = 0;
   int beats_total = 0;
   bit model_direct = 1'b0;

   int    model_mem [NENT][MAXW];
   int    exp_beat[$];
   string exp_tag[$];
   int    exp_cmp[$];
   int    exp_cmp_beats[$];
   int    exp_fetch[$];
   int    hdr_q[$];
   int    dq_ent[$], dq_hit[$], dq_addr[$], dq_len[$], dq_hlen[$];

   function automatic int hostword(input int addr, input int i);
      return (addr * 7 + i * 13 + 5) & 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // reference model: computes every expected output at posting time
   task automatic send(input int ent, input bit hit, input int addr,
                       input int len, input int hlen, input string tag);
      bit drop;
      drop = !hit && model_direct;
      for (int j = 0; j < hlen; j++) begin
         hdr_q.push_back(hdr_seed & 8'hFF);
         if (!drop) begin
            exp_beat.push_back(hdr_seed & 8'hFF);
            exp_tag.push_back({tag, " R5 header word"});
         end
         hdr_seed++;
      end
      if (!hit && !drop) begin
         for (int i = 0; i < len; i++) model_mem[ent][i] = hostword(addr, i);
         exp_fetch.push_back((addr << 8) | len);
      end
      if (!drop) begin
         for (int i = 0; i < len; i++) begin
            exp_beat.push_back(model_mem[ent][i] | ((i == len - 1) ? 256 : 0));
            exp_tag.push_back({tag, " payload word"});
         end
         beats_total += hlen + len;
      end
      exp_cmp.push_back(ent | (drop ? 256 : 0));
      exp_cmp_beats.push_back(beats_total);
      dq_ent.push_back(ent);
      dq_hit.push_back(int'(hit));
      dq_addr.push_back(addr);
      dq_len.push_back(len);
      dq_hlen.push_back(hlen);
   endtask

   task automatic drain();
      while (exp_cmp.size() > 0 || dq_ent.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // output ready pattern
   initial forever begin
      @(posedge clk);
      #1;
      cycles++;
      tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cycles % 3 != 0) : 1'b0;
   end

   // descriptor source
   initial begin : drv_desc
      bit hs;
      forever begin
         @(negedge clk);
         hs = desc_valid && desc_ready;
         @(posedge clk);
         #1;
         if (hs) begin
            void'(dq_ent.pop_front()); void'(dq_hit.pop_front());
            void'(dq_addr.pop_front()); void'(dq_len.pop_front());
            void'(dq_hlen.pop_front());
         end
         if (dq_ent.size() > 0) begin
            desc_valid   = 1'b1;
            desc_entry   = ENT_W'(dq_ent[0]);
            desc_hit     = dq_hit[0][0];
            desc_addr    = ADDR_W'(dq_addr[0]);
            desc_len     = (IDX_W + 1)'(dq_len[0]);
            desc_hdr_len = HL_W'(dq_hlen[0]);
         end else begin
            desc_valid = 1'b0;
         end
      end
   end

   // header source
   initial begin : drv_hdr
      bit hs;
      forever begin
         @(negedge clk);
         hs = hdr_valid && hdr_ready;
         @(posedge clk);
         #1;
         if (hs) void'(hdr_q.pop_front());
         hdr_valid = (hdr_q.size() > 0);
         hdr_data  = (hdr_q.size() > 0) ? DATA_W'(hdr_q[0]) : '0;
      end
   end

   // host memory responder
   initial begin : host_mem
      int a, n;
      forever begin
         @(negedge clk);
         if (rst_n && fetch_req) begin
            a = int'(fetch_addr);
            n = int'(fetch_len);
            if (exp_fetch.size() == 0) begin
               chk(1'b0, "R2/R6 unexpected fetch", (a << 8) | n, -1);
            end else begin
               chk(((a << 8) | n) == exp_fetch[0], "R3 fetch address/length",
                   (a << 8) | n, exp_fetch[0]);
               void'(exp_fetch.pop_front());
            end
            @(posedge clk); #1; fetch_ack = 1'b1;
            @(posedge clk); #1; fetch_ack = 1'b0;
            for (int i = 0; i < n; i++) begin
               fetch_dvalid = 1'b1;
               fetch_data   = DATA_W'(hostword(a, i));
               @(posedge clk);
               #1;
            end
            fetch_dvalid = 1'b0;
         end
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (exp_beat.size() == 0) begin
               chk(1'b0, "R6 unexpected output word", {23'd0, tx_last, tx_data}, -1);
            end else begin
               chk({23'd0, tx_last, tx_data} == exp_beat[0], exp_tag[0],
                   {23'd0, tx_last, tx_data}, exp_beat[0]);
               void'(exp_beat.pop_front());
               void'(exp_tag.pop_front());
            end
            beats_seen++;
         end
         if (cmp_valid) begin
            if (exp_cmp.size() == 0) begin
               chk(1'b0, "R7 unexpected completion", {23'd0, cmp_dropped, 5'd0, cmp_entry}, -1);
            end else begin
               chk({23'd0, cmp_dropped, 5'd0, cmp_entry} == exp_cmp[0],
                   "R7/R6 completion entry and drop flag",
                   {23'd0, cmp_dropped, 5'd0, cmp_entry}, exp_cmp[0]);
               chk(beats_seen == exp_cmp_beats[0], "R7 completion after last word",
                   beats_seen, exp_cmp_beats[0]);
               void'(exp_cmp.pop_front());
               void'(exp_cmp_beats.pop_front());
            end
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9 during reset
      chk(!tx_valid && !fetch_req && !hdr_ready && !cmp_valid, "R9 outputs idle in reset",
          {tx_valid, fetch_req, hdr_ready, cmp_valid}, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      // R9 after reset
      chk(desc_ready == 1'b1, "R9 desc_ready after reset", desc_ready, 1);
      chk(!tx_valid && !fetch_req && !cmp_valid, "R9 outputs idle after reset",
          {tx_valid, fetch_req, cmp_valid}, 0);

      // R3 miss fills entry 2, R5 two headers
      send(2, 1'b0, 16'h0100, 5, 2, "R3 miss e2");
      // R3 full-length miss, no header (R5 boundary)
      send(3, 1'b0, 16'h0200, MAXW, 0, "R3 maxlen miss e3");
      drain();
      // R2 R4 hit on entry 2 with new headers
      send(2, 1'b1, 16'h0000, 5, 3, "R2 R4 hit e2");
      // R2 shorter hit on entry 3
      send(3, 1'b1, 16'h0000, 7, 0, "R2 partial hit e3");
      drain();

      // R8 backpressure pattern, R4 entry overwrite by later fetch
      rdy_mode = 1;
      send(3, 1'b1, 16'h0000, MAXW, 1, "R8 hit e3 under stall");
      send(2, 1'b0, 16'h0300, 1, 1, "R4 refill e2");
      send(2, 1'b1, 16'h0000, 1, 2, "R4 hit refreshed e2");
      drain();
      rdy_mode = 0;

      // R6 direct mode: drops and a normal hit
      direct_mode = 1'b1;
      model_direct = 1'b1;
      send(3, 1'b0, 16'h0400, 6, 2, "R6 drop with headers");
      send(3, 1'b1, 16'h0000, 4, 1, "R6 hit in direct mode");
      send(5, 1'b0, 16'h0500, 3, 0, "R6 drop no headers");
      drain();
      direct_mode = 1'b0;
      model_direct = 1'b0;
      // R6 entry 3 still holds old payload after drop
      send(3, 1'b1, 16'h0000, 3, 0, "R6 R4 entry kept after drop");
      drain();

      // R1 queue fills while the output is stalled
      rdy_mode = 2;
      send(2, 1'b1, 16'h0000, 1, 0, "R1 order a");
      send(3, 1'b1, 16'h0000, 2, 1, "R1 order b");
      send(6, 1'b0, 16'h0600, 4, 0, "R1 order c");
      send(2, 1'b1, 16'h0000, 1, 1, "R1 order d");
      send(6, 1'b1, 16'h0000, 4, 2, "R1 order e");
      send(3, 1'b1, 16'h0000, 5, 0, "R1 order f");
      repeat (14) @(negedge clk);
      chk(desc_ready == 1'b0, "R1 desc_ready low when full", desc_ready, 0);
      rdy_mode = 0;
      drain();

      chk(exp_fetch.size() == 0, "R3 all expected fetches issued", exp_fetch.size(), 0);
      chk(exp_beat.size() == 0, "R5 all expected words sent", exp_beat.size(), 0);
      chk(hdr_q.size() == 0, "R6 all header words consumed", hdr_q.size(), 0);
      finish_run();
   end

endmodule